// File: doc/BRIEF.md
# Eager Broadcast Handshake Splitter

This control block takes one req/ack input channel and copies each token onto a parameterised number of output channels. The outputs are independent. Each output may accept the token in any cycle. A one-bit register per output records that the output has already taken the current token, so that output is not asked a second time. The input is acknowledged in the cycle when every output has either taken the token earlier or takes it now. In that same cycle all records clear, ready for the next token.

The block carries no data. The payload fans out to the consumers as plain wires, and this block only decides when each consumer's copy is valid and when the producer may move on. The output count is the parameter `N_OUT`, which must be at least 2. The output request and acknowledge lines are packed vectors, with bit k belonging to output k. Reset is synchronous and active-low.

Top module: `eager_fork_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every per-output record is cleared. Right after reset, a raised `in_req` makes all `out_req` bits 1 and leaves `in_ack` at 0 until acknowledges arrive.
- R2: `out_req[k]` is 1 exactly when `in_req` is 1 and output k has not yet taken the current token.
- R3: `in_ack` is 1 exactly when, for every k, `out_ack[k]` is 1 or `out_req[k]` is 0. This is combinational, with no added cycle.
- R4: An output that completes a handshake (`out_req[k]` and `out_ack[k]` both 1 at a clock edge) while `in_ack` is 0 keeps `out_req[k]` at 0 until the token completes, however long the other outputs stall.
- R5: After a clock edge at which `in_ack` was 1, every record is clear. If `in_req` is still 1, all `out_req` bits are 1 for the next token.
- R6: While `in_req` is 0, all `out_req` bits are 0 and `in_ack` is 1, whatever `out_ack` holds.
- R7: If all outputs acknowledge in the first cycle of a token, `in_ack` rises in that same cycle.
- R8: Under arbitrary per-output backpressure, each output completes exactly one handshake per input token. No token is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; records update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | 1 | Producer has a token; held until `in_ack` |
| in_ack | output | 1 | Token delivered to every output |
| out_req | output | N_OUT | Per-output request; bit k for output k |
| out_ack | input | N_OUT | Per-output acknowledge; bit k for output k |

## Verification
A record that is stuck clear shows up at the port as a second request to an output that already took the token, one cycle after that output's handshake. A record that is stuck set shows up as a missing request on the following token, or as an early `in_ack`. A record that fails to clear on completion shows up as a missing request in the cycle right after `in_ack`. A per-output handshake count, checked at each token completion under random stalls, exposes any of these faults within one token.

// File: rtl/efk_pkg.sv
// Package: shared types for the eager broadcast splitter.
// Assumes: nothing; it only holds declarations.
package efk_pkg;
    // Smallest sensible output count.
    localparam int unsigned EFK_MIN_WAYS = 2;

    // State of one output's per-token record.
    typedef enum logic {
        REC_OPEN  = 1'b0,
        REC_TAKEN = 1'b1
    } rec_state_e;
endpackage

// File: rtl/efk_lane.sv
// Module: one output lane of the splitter.
// Holds the "already taken" record for one output, gates that output's
// request, and reports whether the output is served in this cycle.
// Assumes: `fire` is the splitter's input acknowledge, and the upstream
// request is held until `fire`.
module efk_lane
    import efk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_req,
    input  logic fire,
    input  logic dn_ack,
    output logic dn_req,
    output logic served
);
    rec_state_e rec_q;

    // Request this output only while it still owes a handshake.
    always_comb dn_req = up_req && (rec_q == REC_OPEN);

    // Served: takes the token now, or has nothing to take.
    always_comb served = dn_ack || !dn_req;

    // Record a handshake; clear once the whole token completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rec_q <= REC_OPEN;
        else if (served && !fire)
            rec_q <= REC_TAKEN;
        else
            rec_q <= REC_OPEN;
    end
endmodule

// File: rtl/efk_all_done.sv
// Module: wide AND of the per-lane served terms.
// Built as a ripple chain through generate, so the width is free.
// Assumes: WIDTH >= 1.
module efk_all_done #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] bits,
    output logic             all_set
);
    logic [WIDTH:0] chain;

    // Seed the chain with a true value.
    always_comb chain[0] = 1'b1;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_link
            // Fold in one lane's served term.
            always_comb chain[g+1] = chain[g] & bits[g];
        end
    endgenerate

    // Final stage of the chain.
    always_comb all_set = chain[WIDTH];
endmodule

// File: rtl/eager_fork_ctrl.sv
// Module: eager broadcast handshake splitter (top).
// One req/ack input, N_OUT req/ack outputs. Each output takes each token
// once, at its own pace. The input is acknowledged when all outputs are served.
// Assumes: N_OUT >= efk_pkg::EFK_MIN_WAYS; in_req is held until in_ack;
// synchronous active-low reset.
module eager_fork_ctrl #(
    parameter int unsigned N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_req,
    output logic             in_ack,
    output logic [N_OUT-1:0] out_req,
    input  logic [N_OUT-1:0] out_ack
);
    localparam int unsigned LANES = N_OUT;

    logic [LANES-1:0] served;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            efk_lane u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .up_req (in_req),
                .fire   (in_ack),
                .dn_ack (out_ack[k]),
                .dn_req (out_req[k]),
                .served (served[k])
            );
        end
    endgenerate

    efk_all_done #(.WIDTH(LANES)) u_done (
        .bits    (served),
        .all_set (in_ack)
    );
endmodule

// File: rtl/eager_fork_ctrl_chk.sv
// Module: protocol checker for eager_fork_ctrl, attached with bind.
// Assumes: the same clock and reset as the checked block.
module eager_fork_ctrl_chk #(
    parameter int unsigned N_OUT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_req,
    input logic             in_ack,
    input logic [N_OUT-1:0] out_req,
    input logic [N_OUT-1:0] out_ack
);
    // R6: an idle input asks nothing and is acknowledged.
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_req |-> (out_req == '0) && in_ack);

    // R5: completion reopens every output for the next token.
    a_r5_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        in_ack |=> (!in_req || (&out_req)));

    genvar k;
    generate
        for (k = 0; k < N_OUT; k++) begin : g_chk
            // R2: no output requests without an input token.
            a_r2_req_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
                out_req[k] |-> in_req);
            // R4: a served output stays quiet until completion.
            a_r4_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
                (out_req[k] && out_ack[k] && !in_ack) |=> !out_req[k]);
            // R3: input ack implies this output is served.
            a_r3_ack_served: assert property (@(posedge clk) disable iff (!rst_n)
                in_ack |-> (out_ack[k] || !out_req[k]));
            // R3: a pending unacked request blocks the input ack.
            a_r3_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
                (out_req[k] && !out_ack[k]) |-> !in_ack);
        end
    endgenerate
endmodule

bind eager_fork_ctrl eager_fork_ctrl_chk #(.N_OUT(N_OUT)) u_chk (.*);

// File: tb/eager_fork_ctrl_test.sv
`timescale 1ns/1ps
module eager_fork_ctrl_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_req = 1'b0;
    logic         in_ack;
    logic [N-1:0] out_req;
    logic [N-1:0] out_ack = '0;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    eager_fork_ctrl #(.N_OUT(N)) uut (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
        .out_req(out_req), .out_ack(out_ack)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, then settle before checking.
    task automatic step(input logic r, input logic [N-1:0] a);
        @(negedge clk);
        in_req  = r;
        out_ack = a;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(1'b1, '0);
        step(1'b1, '0);
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 out_req after reset", 32'(out_req), 32'({N{1'b1}}));
        check("R1 in_ack after reset", 32'(in_ack), 32'd0);
    endtask

    task automatic t_idle();
        step(1'b0, 4'b1010);
        check("R6 out_req idle", 32'(out_req), 32'd0);
        check("R6 in_ack idle", 32'(in_ack), 32'd1);
        step(1'b0, 4'b0000);
        check("R6 in_ack idle no ack", 32'(in_ack), 32'd1);
    endtask

    task automatic t_all_at_once();
        step(1'b1, '1);
        check("R7 same-cycle in_ack", 32'(in_ack), 32'd1);
        step(1'b1, '0);
        check("R5 all reopened", 32'(out_req), 32'({N{1'b1}}));
        check("R3 no ack, no in_ack", 32'(in_ack), 32'd0);
    endtask

    task automatic t_staggered();
        step(1'b1, 4'b0001);
        check("R3 partial ack", 32'(in_ack), 32'd0);
        step(1'b1, 4'b0000);
        check("R4 out0 dropped", 32'(out_req), 32'b1110);
        for (int i = 0; i < 6; i++) step(1'b1, 4'b0001);
        check("R4 out0 still quiet", 32'(out_req), 32'b1110);
        step(1'b1, 4'b0100);
        check("R2 after out2", 32'(in_ack), 32'd0);
        step(1'b1, 4'b0000);
        check("R2 out_req gating", 32'(out_req), 32'b1010);
        step(1'b1, 4'b1010);
        check("R3 served via taken", 32'(in_ack), 32'd1);
        step(1'b1, 4'b0000);
        check("R5 reopen after stagger", 32'(out_req), 32'({N{1'b1}}));
        step(1'b0, 4'b0000);
    endtask

    task automatic t_random();
        int cnt[N];
        int tokens = 0;
        logic pending = 1'b0;
        for (int k = 0; k < N; k++) cnt[k] = 0;
        for (int c = 0; c < 3000; c++) begin
            logic r;
            logic [N-1:0] hs;
            logic fin;
            r = pending ? 1'b1 : (($urandom % 10) < 7);
            step(r, N'($urandom));
            for (int k = 0; k < N; k++)
                check("R2 random out_req", 32'(out_req[k]), 32'(r && cnt[k] == 0));
            hs  = out_req & out_ack;
            fin = in_req && in_ack;
            @(posedge clk);
            for (int k = 0; k < N; k++) if (hs[k]) cnt[k]++;
            if (fin) begin
                for (int k = 0; k < N; k++) begin
                    check("R8 one handshake per token", 32'(cnt[k]), 32'd1);
                    cnt[k] = 0;
                end
                tokens++;
                pending = 1'b0;
            end else begin
                pending = r;
            end
        end
        checks++;
        if (tokens < 100) begin
            fails++;
            $display("FAIL R8 tokens actual=%0d expected>=100", tokens);
        end
    endtask

    initial begin
        #2000000;
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_all_at_once();
        t_staggered();
        t_random();
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule